// File: doc/BRIEF.md
# Performance Monitor Counter Unit

A bank of programmable event counters and one dedicated 64-bit cycle counter, reached through a simple single-cycle register port. Each event counter owns a select register that picks one of the incoming event pulses (or a software increment, or the clock itself) and filters counting by the current privilege level. A control register enables counting globally, clears counters, turns on a divide-by-64 prescale for the cycle counter, and chooses whether that counter reports overflow at 32 or at 64 bits.

Counter enables and interrupt enables are each written through a pair of set and clear addresses. Any counter that wraps raises a sticky overflow flag, which software clears by writing ones. A level interrupt stays high while any flag is set and its interrupt enable is set. In every per-counter mask, event counter i uses bit i and the cycle counter uses bit 31.

Top module: `perf_mon_unit`

## Requirements
- R1: After synchronous reset, every counter, select register, enable mask and overflow flag is zero, `irq` is low, and the control register (address 0x00) reads with the event-counter count NUM_CNT in bits 15:11 and zero elsewhere.
- R2: Control register at 0x00: only bits 6:0 are writable; bit 0 is the global enable, and with it low no counter changes except through writes. Writing 1 to bit 1 zeroes all event counters and writing 1 to bit 2 zeroes the cycle counter and its prescaler; bits 1 and 2 are actions and always read back 0.
- R3: An event counter adds one on a clock edge when the global enable, its own enable bit, its selected event and its privilege filter are all true in that cycle.
- R4: Select register of counter i is at 0x30+i, readback masked with 0xC800FFFF. `priv_lvl` 0 counts unless bit 30 is set, level 1 counts unless bit 31 is set, level 2 counts only when bit 27 is set, and level 3 never counts.
- R5: Event number (select bits 15:0) 0x0000 counts a write of 1 to bit i of the software-increment address 0x06; 0x0011 counts every clock; any other number below NUM_EVT_IN counts `evt_in[number]`; all other numbers never count. Address 0x06 reads 0.
- R6: The cycle counter is 64 bits, read low word at 0x08 and high word at 0x09, and counts every clock while global enable and mask bit 31 are set; with control bit 3 set it counts once every 64 such clocks.
- R7: An event counter incrementing from 0xFFFFFFFF wraps to 0 and sets overflow flag i. The cycle counter sets flag 31 when its low 32 bits wrap, or, with control bit 6 set, only when all 64 bits wrap.
- R8: Writing ones to 0x01 sets, and to 0x02 clears, counter enable bits; 0x03 and 0x04 do the same for interrupt enable bits. Either address of a pair reads the current mask; bits other than 0..NUM_CNT-1 and 31 are ignored and read 0.
- R9: Overflow flags at 0x05 are sticky; writing 1 to a bit clears it, but an overflow in the same cycle as its clear leaves the flag set.
- R10: `irq` is a registered level, high exactly while some overflow flag and the matching interrupt enable bit are both set.
- R11: Counter i is read and written at 0x10+i; a write in the same cycle as an increment wins, stores the written value and raises no flag.
- R12: `rd_data` presents the register at `rd_addr` one clock later; unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read address |
| rd_data | output | 32 | Registered read data |
| priv_lvl | input | 2 | Current privilege level 0..3 |
| evt_in | input | NUM_EVT_IN | Event pulses, one bit per event number |
| irq | output | 1 | Overflow interrupt level |

## Verification
Two collisions matter: a counter wrapping in the very cycle software writes one to clear its overflow flag, and a direct counter write landing in a cycle where that counter would also have incremented. Both are provoked by loading a counter that counts every clock with a value just below the wrap (or by writing it while it runs) and timing the next register write to coincide. The bench judges each against its own cycle model, expecting the flag to survive the clear and the written value to replace the increment.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;
  localparam int CYC_BIT = 31;

  // register addresses
  localparam logic [ADDR_W-1:0] A_CTRL     = 8'h00;
  localparam logic [ADDR_W-1:0] A_CEN_SET  = 8'h01;
  localparam logic [ADDR_W-1:0] A_CEN_CLR  = 8'h02;
  localparam logic [ADDR_W-1:0] A_IEN_SET  = 8'h03;
  localparam logic [ADDR_W-1:0] A_IEN_CLR  = 8'h04;
  localparam logic [ADDR_W-1:0] A_OVF      = 8'h05;
  localparam logic [ADDR_W-1:0] A_SWINC    = 8'h06;
  localparam logic [ADDR_W-1:0] A_CYC_LO   = 8'h08;
  localparam logic [ADDR_W-1:0] A_CYC_HI   = 8'h09;
  localparam logic [ADDR_W-1:0] A_CNT_BASE = 8'h10;
  localparam logic [ADDR_W-1:0] A_SEL_BASE = 8'h30;

  // control bit positions
  localparam int CTRL_EN    = 0;
  localparam int CTRL_EVRST = 1;
  localparam int CTRL_CYRST = 2;
  localparam int CTRL_DIV   = 3;
  localparam int CTRL_LONG  = 6;
  localparam int CTRL_W     = 7;
  localparam logic [CTRL_W-1:0] CTRL_KEEP = 7'b111_1001;

  // select register layout
  localparam logic [DATA_W-1:0] SEL_WMASK = 32'hC800_FFFF;
  localparam int SEL_NO_L1 = 31;
  localparam int SEL_NO_L0 = 30;
  localparam int SEL_L2    = 27;
  localparam int EVNUM_W   = 16;
  localparam logic [EVNUM_W-1:0] EV_SOFT   = 16'h0000;
  localparam logic [EVNUM_W-1:0] EV_CLOCKS = 16'h0011;

  typedef enum logic [1:0] {
    PL_USER = 2'd0,
    PL_SUP  = 2'd1,
    PL_HYP  = 2'd2,
    PL_MON  = 2'd3
  } priv_e;

  function automatic logic priv_pass(input logic [DATA_W-1:0] sel, input logic [1:0] lvl);
    case (priv_e'(lvl))
      PL_USER: priv_pass = !sel[SEL_NO_L0];
      PL_SUP:  priv_pass = !sel[SEL_NO_L1];
      PL_HYP:  priv_pass = sel[SEL_L2];
      default: priv_pass = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/pmu_evt_counter.sv
module pmu_evt_counter
  import pmu_pkg::*;
#(
  parameter int NUM_EVT_IN = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  glb_en,
  input  logic                  cnt_en,
  input  logic [1:0]            priv_lvl,
  input  logic [NUM_EVT_IN-1:0] evt_in,
  input  logic                  sw_inc,
  input  logic                  clr_all,
  input  logic                  wr_cnt,
  input  logic                  wr_sel,
  input  logic [DATA_W-1:0]     wr_data,
  output logic [DATA_W-1:0]     cnt_q,
  output logic [DATA_W-1:0]     sel_q,
  output logic                  ovf_o
);

  localparam int IDX_W = (NUM_EVT_IN > 1) ? $clog2(NUM_EVT_IN) : 1;
  localparam logic [EVNUM_W-1:0] EV_LIMIT = EVNUM_W'(NUM_EVT_IN);

  logic [EVNUM_W-1:0] ev_num;
  logic               ev_hit;
  logic               inc;

  always_comb begin
    ev_num = sel_q[EVNUM_W-1:0];
    if (ev_num == EV_SOFT)        ev_hit = sw_inc;
    else if (ev_num == EV_CLOCKS) ev_hit = 1'b1;
    else if (ev_num < EV_LIMIT)   ev_hit = evt_in[ev_num[IDX_W-1:0]];
    else                          ev_hit = 1'b0;
  end

  assign inc   = glb_en && cnt_en && ev_hit && priv_pass(sel_q, priv_lvl);
  assign ovf_o = inc && !clr_all && !wr_cnt && (cnt_q == '1);

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (clr_all) cnt_q <= '0;
    else if (wr_cnt)  cnt_q <= wr_data;
    else if (inc)     cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)         sel_q <= '0;
    else if (wr_sel) sel_q <= wr_data & SEL_WMASK;
  end

endmodule

// File: rtl/pmu_cycle_counter.sv
module pmu_cycle_counter
  import pmu_pkg::*;
#(
  parameter int PRE_W = 6,
  parameter int CYC_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              div_en,
  input  logic              long_ovf,
  input  logic              clr,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CYC_W-1:0]  cyc_q,
  output logic              ovf_o
);

  localparam int HALF = CYC_W / 2;

  logic [PRE_W-1:0] pre_q;
  logic             tick;
  logic             inc;
  logic             wrap;

  assign tick  = !div_en || (pre_q == '1);
  assign inc   = run && tick;
  assign wrap  = long_ovf ? (&cyc_q) : (&cyc_q[HALF-1:0]);
  assign ovf_o = inc && !clr && !wr_lo && !wr_hi && wrap;

  always_ff @(posedge clk) begin
    if (rst)      pre_q <= '0;
    else if (clr) pre_q <= '0;
    else if (run) pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)        cyc_q <= '0;
    else if (clr)   cyc_q <= '0;
    else if (wr_lo) cyc_q[HALF-1:0] <= wr_data[HALF-1:0];
    else if (wr_hi) cyc_q[CYC_W-1:HALF] <= wr_data[HALF-1:0];
    else if (inc)   cyc_q <= cyc_q + 1'b1;
  end

endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit
  import pmu_pkg::*;
#(
  parameter int NUM_CNT    = 4,
  parameter int NUM_EVT_IN = 32,
  parameter int PRE_W      = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [7:0]            wr_addr,
  input  logic [31:0]           wr_data,
  input  logic [7:0]            rd_addr,
  output logic [31:0]           rd_data,
  input  logic [1:0]            priv_lvl,
  input  logic [NUM_EVT_IN-1:0] evt_in,
  output logic                  irq
);

  localparam int CYC_W = 2 * DATA_W;
  localparam logic [30:0] EVT_MASK = 31'((64'd1 << NUM_CNT) - 64'd1);
  localparam logic [DATA_W-1:0] VALID = {1'b1, EVT_MASK};

  logic [CTRL_W-1:0] ctrl_q;
  logic [DATA_W-1:0] cen_q, ien_q, ovf_q;
  logic [DATA_W-1:0] cen_d, ien_d, ovf_d;
  logic [DATA_W-1:0] ovf_set, ovf_clr, sw_vec;
  logic [DATA_W-1:0] cnt_arr [NUM_CNT];
  logic [DATA_W-1:0] sel_arr [NUM_CNT];
  logic [NUM_CNT-1:0] evt_ovf;
  logic [CYC_W-1:0]  cyc_cnt;
  logic              cyc_ovf;
  logic              wr_ctrl, clr_evt, clr_cyc;
  logic [DATA_W-1:0] rd_mux;

  assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
  assign clr_evt = wr_ctrl && wr_data[CTRL_EVRST];
  assign clr_cyc = wr_ctrl && wr_data[CTRL_CYRST];
  assign sw_vec  = (wr_en && wr_addr == A_SWINC) ? wr_data : '0;
  assign ovf_clr = (wr_en && wr_addr == A_OVF) ? wr_data : '0;

  // event counters
  for (genvar i = 0; i < NUM_CNT; i++) begin : g_evt
    localparam logic [7:0] CNT_A = A_CNT_BASE + 8'(i);
    localparam logic [7:0] SEL_A = A_SEL_BASE + 8'(i);
    pmu_evt_counter #(.NUM_EVT_IN(NUM_EVT_IN)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .glb_en   (ctrl_q[CTRL_EN]),
      .cnt_en   (cen_q[i]),
      .priv_lvl (priv_lvl),
      .evt_in   (evt_in),
      .sw_inc   (sw_vec[i]),
      .clr_all  (clr_evt),
      .wr_cnt   (wr_en && wr_addr == CNT_A),
      .wr_sel   (wr_en && wr_addr == SEL_A),
      .wr_data  (wr_data),
      .cnt_q    (cnt_arr[i]),
      .sel_q    (sel_arr[i]),
      .ovf_o    (evt_ovf[i])
    );
  end

  pmu_cycle_counter #(.PRE_W(PRE_W), .CYC_W(CYC_W)) u_cyc (
    .clk      (clk),
    .rst      (rst),
    .run      (ctrl_q[CTRL_EN] && cen_q[CYC_BIT]),
    .div_en   (ctrl_q[CTRL_DIV]),
    .long_ovf (ctrl_q[CTRL_LONG]),
    .clr      (clr_cyc),
    .wr_lo    (wr_en && wr_addr == A_CYC_LO),
    .wr_hi    (wr_en && wr_addr == A_CYC_HI),
    .wr_data  (wr_data),
    .cyc_q    (cyc_cnt),
    .ovf_o    (cyc_ovf)
  );

  // mask and flag next state
  always_comb begin
    ovf_set = '0;
    ovf_set[NUM_CNT-1:0] = evt_ovf;
    ovf_set[CYC_BIT] = cyc_ovf;
    ovf_d = ((ovf_q & ~ovf_clr) | ovf_set) & VALID;

    cen_d = cen_q;
    if (wr_en && wr_addr == A_CEN_SET) cen_d = cen_q | (wr_data & VALID);
    if (wr_en && wr_addr == A_CEN_CLR) cen_d = cen_q & ~wr_data;

    ien_d = ien_q;
    if (wr_en && wr_addr == A_IEN_SET) ien_d = ien_q | (wr_data & VALID);
    if (wr_en && wr_addr == A_IEN_CLR) ien_d = ien_q & ~wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      cen_q  <= '0;
      ien_q  <= '0;
      ovf_q  <= '0;
      irq    <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= wr_data[CTRL_W-1:0] & CTRL_KEEP;
      cen_q <= cen_d;
      ien_q <= ien_d;
      ovf_q <= ovf_d;
      irq   <= |(ovf_d & ien_d);
    end
  end

  // read path
  always_comb begin
    rd_mux = '0;
    case (rd_addr)
      A_CTRL:               rd_mux = {16'b0, 5'(NUM_CNT), 4'b0, ctrl_q};
      A_CEN_SET, A_CEN_CLR: rd_mux = cen_q;
      A_IEN_SET, A_IEN_CLR: rd_mux = ien_q;
      A_OVF:                rd_mux = ovf_q;
      A_CYC_LO:             rd_mux = cyc_cnt[DATA_W-1:0];
      A_CYC_HI:             rd_mux = cyc_cnt[CYC_W-1:DATA_W];
      default: begin
        for (int i = 0; i < NUM_CNT; i++) begin
          if (rd_addr == A_CNT_BASE + 8'(i)) rd_mux = cnt_arr[i];
          if (rd_addr == A_SEL_BASE + 8'(i)) rd_mux = sel_arr[i];
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end

endmodule

// File: rtl/pmu_checker.sv
module pmu_checker
  import pmu_pkg::*;
#(
  parameter int NUM_CNT = 4
) (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic [7:0]  wr_addr,
  input logic [31:0] wr_data,
  input logic        irq,
  input logic [6:0]  ctrl_q,
  input logic [31:0] cen_q,
  input logic [31:0] ien_q,
  input logic [31:0] ovf_q,
  input logic [63:0] cyc_q
);

  localparam logic [30:0] EVT_MASK = 31'((64'd1 << NUM_CNT) - 64'd1);
  localparam logic [31:0] VALID = {1'b1, EVT_MASK};

  logic [31:0] clr_vec, hold_vec, set_vec;
  assign clr_vec  = (wr_en && wr_addr == A_OVF) ? wr_data : '0;
  assign hold_vec = ovf_q & ~clr_vec;
  assign set_vec  = wr_data & VALID;

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
    irq == |(ovf_q & ien_q)); // R10

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((ovf_q & $past(hold_vec)) == $past(hold_vec))); // R9

  AST_CEN_SET: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_CEN_SET) |=> ((cen_q & $past(set_vec)) == $past(set_vec))); // R8

  AST_IEN_CLR: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_IEN_CLR) |=> ((ien_q & $past(wr_data)) == 32'd0)); // R8

  AST_CYC_STEP: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> (cyc_q == $past(cyc_q) || cyc_q == $past(cyc_q) + 64'd1)); // R6

  AST_GLB_OFF: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q[0] && !wr_en) |=> $stable(cyc_q)); // R2

endmodule

bind perf_mon_unit pmu_checker #(.NUM_CNT(NUM_CNT)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .irq     (irq),
  .ctrl_q  (ctrl_q),
  .cen_q   (cen_q),
  .ien_q   (ien_q),
  .ovf_q   (ovf_q),
  .cyc_q   (cyc_cnt)
);

// File: tb/perf_mon_unit_tb.sv
module perf_mon_unit_tb;

  localparam int CLK_P = 10;
  localparam int NC    = 4;
  localparam int NE    = 32;
  localparam logic [31:0] VMASK = 32'h8000_000F;

  logic        clk = 0;
  logic        rst = 1;
  logic        wr_en = 0;
  logic [7:0]  wr_addr = 0;
  logic [31:0] wr_data = 0;
  logic [7:0]  rd_addr = 0;
  logic [31:0] rd_data;
  logic [1:0]  priv_lvl = 0;
  logic [NE-1:0] evt_in = 0;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  string cur_req = "R1";

  perf_mon_unit #(.NUM_CNT(NC), .NUM_EVT_IN(NE)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .priv_lvl(priv_lvl), .evt_in(evt_in), .irq(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [6:0]  m_ctrl;
  logic [31:0] m_cen, m_ien, m_ovf;
  logic [31:0] m_cnt [NC];
  logic [31:0] m_sel [NC];
  logic [63:0] m_cyc;
  int          m_pre;
  logic [31:0] exp_rd;
  logic        exp_irq;

  function automatic logic [31:0] m_read(input logic [7:0] a);
    m_read = 0;
    if (a == 8'h00) m_read = {16'b0, 5'(NC), 4'b0, m_ctrl};
    else if (a == 8'h01 || a == 8'h02) m_read = m_cen;
    else if (a == 8'h03 || a == 8'h04) m_read = m_ien;
    else if (a == 8'h05) m_read = m_ovf;
    else if (a == 8'h08) m_read = m_cyc[31:0];
    else if (a == 8'h09) m_read = m_cyc[63:32];
    else for (int i = 0; i < NC; i++) begin
      if (a == 8'h10 + 8'(i)) m_read = m_cnt[i];
      if (a == 8'h30 + 8'(i)) m_read = m_sel[i];
    end
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_ctrl = 0; m_cen = 0; m_ien = 0; m_ovf = 0; m_cyc = 0; m_pre = 0;
      for (int i = 0; i < NC; i++) begin m_cnt[i] = 0; m_sel[i] = 0; end
      exp_rd = 0; exp_irq = 0;
    end else begin
      logic [31:0] setv;
      logic glb, run, hit, pass, tick;
      int num;
      exp_rd = m_read(rd_addr);
      setv = 0;
      glb = m_ctrl[0];
      for (int i = 0; i < NC; i++) begin
        num = int'(m_sel[i][15:0]);
        if (num == 0)       hit = wr_en && wr_addr == 8'h06 && wr_data[i];
        else if (num == 17) hit = 1;
        else if (num < NE)  hit = evt_in[num];
        else                hit = 0;
        case (priv_lvl)
          2'd0: pass = !m_sel[i][30];
          2'd1: pass = !m_sel[i][31];
          2'd2: pass = m_sel[i][27];
          default: pass = 0;
        endcase
        if (wr_en && wr_addr == 8'h00 && wr_data[1]) m_cnt[i] = 0;
        else if (wr_en && wr_addr == 8'h10 + 8'(i)) m_cnt[i] = wr_data;
        else if (glb && m_cen[i] && hit && pass) begin
          if (m_cnt[i] == 32'hFFFF_FFFF) setv[i] = 1;
          m_cnt[i] = m_cnt[i] + 1;
        end
        if (wr_en && wr_addr == 8'h30 + 8'(i)) m_sel[i] = wr_data & 32'hC800_FFFF;
      end
      run = glb && m_cen[31];
      if (wr_en && wr_addr == 8'h00 && wr_data[2]) begin
        m_cyc = 0; m_pre = 0;
      end else begin
        tick = run && (!m_ctrl[3] || m_pre == 63);
        if (wr_en && wr_addr == 8'h08) m_cyc[31:0] = wr_data;
        else if (wr_en && wr_addr == 8'h09) m_cyc[63:32] = wr_data;
        else if (tick) begin
          if (m_ctrl[6] ? (m_cyc == 64'hFFFF_FFFF_FFFF_FFFF) : (m_cyc[31:0] == 32'hFFFF_FFFF))
            setv[31] = 1;
          m_cyc = m_cyc + 1;
        end
        if (run) m_pre = (m_pre + 1) % 64;
      end
      m_ovf = ((m_ovf & ~((wr_en && wr_addr == 8'h05) ? wr_data : 32'h0)) | setv) & VMASK;
      if (wr_en && wr_addr == 8'h01) m_cen = m_cen | (wr_data & VMASK);
      if (wr_en && wr_addr == 8'h02) m_cen = m_cen & ~wr_data;
      if (wr_en && wr_addr == 8'h03) m_ien = m_ien | (wr_data & VMASK);
      if (wr_en && wr_addr == 8'h04) m_ien = m_ien & ~wr_data;
      if (wr_en && wr_addr == 8'h00) m_ctrl = wr_data[6:0] & 7'b111_1001;
      exp_irq = |(m_ovf & m_ien);
    end
  end

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk(rd_data == exp_rd, cur_req, 64'(rd_data), 64'(exp_rd));
      chk(irq == exp_irq, {cur_req, " R10"}, 64'(irq), 64'(exp_irq));
    end
  end

  // read address: rotating sweep, or a directed address
  logic       dir_rd = 0;
  logic [7:0] dir_addr = 0;
  int         rot_k = 0;

  function automatic logic [7:0] rot_addr(input int k);
    case (k % 16)
      0: rot_addr = 8'h00;  1: rot_addr = 8'h01;  2: rot_addr = 8'h03;  3: rot_addr = 8'h05;
      4: rot_addr = 8'h06;  5: rot_addr = 8'h08;  6: rot_addr = 8'h09;  7: rot_addr = 8'h10;
      8: rot_addr = 8'h11;  9: rot_addr = 8'h12; 10: rot_addr = 8'h13; 11: rot_addr = 8'h30;
      12: rot_addr = 8'h31; 13: rot_addr = 8'h32; 14: rot_addr = 8'h33; default: rot_addr = 8'h7F;
    endcase
  endfunction

  always @(negedge clk) begin
    if (dir_rd) rd_addr <= dir_addr;
    else begin
      rd_addr <= rot_addr(rot_k);
      rot_k <= rot_k + 1;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    #1 dir_addr = a; dir_rd = 1;
    @(negedge clk);
    @(negedge clk);
    #1 v = rd_data;
    dir_rd = 0;
  endtask

  task automatic pulse(input int bitn);
    @(negedge clk);
    evt_in[bitn] = 1;
    @(negedge clk);
    evt_in[bitn] = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 100000);
    chk(0, "WATCHDOG", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    repeat (5) @(negedge clk);
    rst = 0;

    cur_req = "R1";
    rd(8'h00, v); chk(v == 32'h0000_2000, "R1 ctrl", v, 32'h2000);
    rd(8'h05, v); chk(v == 0, "R1 ovf", v, 0);
    rd(8'h01, v); chk(v == 0, "R1 cen", v, 0);
    chk(irq == 0, "R1 irq", irq, 0);

    cur_req = "R8";
    wr(8'h01, 32'hFFFF_FFFF);
    rd(8'h01, v); chk(v == 32'h8000_000F, "R8 set", v, 32'h8000_000F);
    wr(8'h02, 32'h1);
    rd(8'h02, v); chk(v == 32'h8000_000E, "R8 clr", v, 32'h8000_000E);
    wr(8'h01, 32'h1);

    cur_req = "R2";
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, v); chk(v == 32'h0000_2079, "R2 ctrl mask", v, 32'h2079);
    wr(8'h00, 32'h1);

    cur_req = "R3";
    wr(8'h30, 32'h3);
    repeat (5) pulse(3);
    rd(8'h10, v); chk(v == 5, "R3 count", v, 5);
    wr(8'h02, 32'h1);
    repeat (2) pulse(3);
    rd(8'h10, v); chk(v == 5, "R3 disabled", v, 5);
    wr(8'h01, 32'h1);

    cur_req = "R4";
    wr(8'h31, 32'h4000_0003);
    repeat (2) pulse(3);
    rd(8'h11, v); chk(v == 0, "R4 level0 blocked", v, 0);
    priv_lvl = 1; repeat (2) pulse(3);
    priv_lvl = 2; repeat (2) pulse(3);
    wr(8'h31, 32'h0800_0003);
    pulse(3);
    priv_lvl = 3; pulse(3);
    rd(8'h11, v); chk(v == 3, "R4 filter", v, 3);
    rd(8'h10, v); chk(v == 9, "R4 unfiltered", v, 9);
    wr(8'h32, 32'hFFFF_FFFF);
    rd(8'h32, v); chk(v == 32'hC800_FFFF, "R4 sel mask", v, 32'hC800_FFFF);
    wr(8'h32, 32'h0);
    priv_lvl = 0;

    cur_req = "R5";
    repeat (3) wr(8'h06, 32'h5);
    rd(8'h12, v); chk(v == 3, "R5 soft inc", v, 3);
    rd(8'h10, v); chk(v == 9, "R5 soft ignored", v, 9);
    wr(8'h33, 32'h40);
    @(negedge clk); evt_in = '1; idle(3); evt_in = '0;
    rd(8'h13, v); chk(v == 0, "R5 out of range", v, 0);
    rd(8'h10, v); chk(v == 12, "R5 evt", v, 12);
    wr(8'h33, 32'h11);
    idle(20);

    cur_req = "R7";
    wr(8'h10, 32'hFFFF_FFFE);
    repeat (2) pulse(3);
    rd(8'h10, v); chk(v == 0, "R7 wrap", v, 0);
    rd(8'h05, v); chk(v == 32'h1, "R7 flag", v, 1);

    cur_req = "R10";
    wr(8'h03, 32'h1);
    chk(irq == 1, "R10 irq set", irq, 1);
    idle(3);
    chk(irq == 1, "R10 irq held", irq, 1);
    wr(8'h05, 32'h1);
    chk(irq == 0, "R10 irq clear", irq, 0);

    cur_req = "R9";
    rd(8'h05, v); chk(v == 0, "R9 cleared", v, 0);
    wr(8'h13, 32'hFFFF_FFFE);
    wr(8'h05, 32'h8);
    rd(8'h05, v); chk(v == 32'h8, "R9 set beats clear", v, 8);
    wr(8'h05, 32'h8);
    rd(8'h05, v); chk(v == 0, "R9 clear", v, 0);

    cur_req = "R7";
    wr(8'h08, 32'hFFFF_FFF0);
    idle(30);
    rd(8'h05, v); chk(v == 32'h8000_0000, "R7 cyc 32", v, 32'h8000_0000);
    rd(8'h09, v); chk(v == 1, "R7 cyc hi", v, 1);
    wr(8'h05, 32'h8000_0000);
    wr(8'h00, 32'h41);
    wr(8'h09, 32'h0);
    wr(8'h08, 32'hFFFF_FFF0);
    idle(30);
    rd(8'h05, v); chk(v == 0, "R7 long no flag", v, 0);
    wr(8'h09, 32'hFFFF_FFFF);
    wr(8'h08, 32'hFFFF_FFF0);
    idle(30);
    rd(8'h05, v); chk(v == 32'h8000_0000, "R7 long flag", v, 32'h8000_0000);
    rd(8'h09, v); chk(v == 0, "R7 long wrap", v, 0);
    wr(8'h05, 32'h8000_0000);

    cur_req = "R6";
    wr(8'h00, 32'h0D);
    idle(200);
    rd(8'h08, v); chk(v >= 2 && v <= 4, "R6 prescale", v, 3);
    wr(8'h00, 32'h1);
    idle(40);

    cur_req = "R2";
    wr(8'h00, 32'h0);
    rd(8'h08, v); idle(10); rd(8'h08, v2);
    chk(v == v2, "R2 global off", v2, v);
    wr(8'h00, 32'h4);
    rd(8'h08, v); chk(v == 0, "R2 cyc reset", v, 0);
    wr(8'h00, 32'h2);
    rd(8'h10, v); chk(v == 0, "R2 evt reset", v, 0);
    rd(8'h13, v); chk(v == 0, "R2 evt reset 3", v, 0);
    rd(8'h00, v); chk(v == 32'h2000, "R2 self clear", v, 32'h2000);

    cur_req = "R11";
    wr(8'h00, 32'h1);
    idle(5);
    wr(8'h13, 32'h100);
    wr(8'h02, 32'h8);
    rd(8'h13, v); chk(v == 32'h102, "R11 write wins", v, 32'h102);
    rd(8'h05, v); chk(v == 0, "R11 no flag", v, 0);

    cur_req = "R12";
    rd(8'h7F, v); chk(v == 0, "R12 unmapped", v, 0);
    rd(8'h06, v); chk(v == 0, "R12 swinc reads 0", v, 0);
    rd(8'h07, v); chk(v == 0, "R12 gap", v, 0);
    idle(20);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule